// File: doc/BRIEF.md
# Register-Packet Command Stream Decoder

This block sits between a command-buffer fetch unit and the internal register bus of a drawing engine. It takes a stream of 32-bit words and treats every five of them as one packet: a header word followed by four data words. The header holds one 8-bit index for each data word. The decoder expands each index into a full byte address in one of two register banks. It then issues one register write per data word, in lane order. A write that targets the padding register is dropped. A write that targets the execute alias is redirected to the drawing-control register and also fires a start pulse toward the engine.

A start pointer and an end pointer bound the stream. The low two bits of the start value give the stream mode. The stream position is the start value with those bits cleared, and it advances by four bytes for every word accepted. Words are accepted only while the position is below the end address and the end value's "hold" bit is clear. A status word and an idle flag report progress.

The controller has four states:
- `ST_HALT`: the stream is stopped.
- `ST_HEAD`: waiting for a header.
- `ST_BODY`: taking data words.
- `ST_SYNC`: waiting for the engine after an execute.

Transitions:
- HALT→HEAD when the pointers allow running.
- HEAD→HALT when they no longer do.
- HEAD→BODY on a header.
- BODY→HEAD after the fourth data word.
- BODY→SYNC after the fourth data word of a packet that contained an execute.
- SYNC→HEAD once the output slot is empty and the engine reports not busy.
- A soft reset forces HEAD from any state.

Top module: `cmdq_decoder`

## Requirements
- R1: A packet is five accepted words: a header, then four data words. The data words are written in lane order, using header bits [7:0], [15:8], [23:16] and [31:24] as the indices of the first to fourth data word.
- R2: Index bit 7 selects the bank: 0 gives base 0x1C00 and 1 gives base 0x2C00. The byte address is base + 4 × index[6:0], so writes land only in 0x1C00–0x1DFF or 0x2C00–0x2DFF.
- R3: A slot decoding to 0x1D00 (index 0x40, the execute alias) is written to 0x1C00 with its data. `exec_pulse` is high for exactly the cycle in which that write is taken by the bus.
- R4: A slot decoding to 0x1C54 (index 0x15, padding) consumes its data word but produces no register write.
- R5: `stream_mode` equals bits [1:0] of the last start value written. Each accepted word advances the position by 4 from the start value with bits [1:0] cleared.
- R6: Words are accepted only while the position is below the end value (bits [1:0] ignored in the compare) and end bit 0 is clear. `alt_path` equals end bit 1.
- R7: `status_word` bit 16 is the engine-busy input, bit 17 is set while the stream is not running, and bit 0 is set while a packet is in progress or a write is pending. `idle` is high exactly when bit 17 is set and bits 16 and 0 are clear.
- R8: At most one register write is presented per cycle. While a write is stalled by `reg_wr_ready` low, its address and data hold and no further data word is accepted.
- R9: After a packet that contained an execute, no header is accepted until the pending write is taken and `eng_busy` is low.
- R10: `soft_rst` returns the decoder to the header-expecting state and discards any partial packet and any pending write. The pointers are kept.
- R11: After reset: no write is pending, `word_ready` is low, `status_word` bit 17 is set and `idle` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous decoder restart |
| start_wr | input | 1 | Load the start pointer |
| start_val | input | 32 | Start byte address; bits [1:0] give the stream mode |
| end_wr | input | 1 | Load the end pointer |
| end_val | input | 32 | End byte address; bit 0 holds, bit 1 selects the alternate path |
| word_valid | input | 1 | Stream word offered |
| word_data | input | 32 | Stream word |
| word_ready | output | 1 | Stream word accepted this cycle when valid |
| reg_wr_valid | output | 1 | Register write strobe |
| reg_wr_ready | input | 1 | Register bus takes the write |
| reg_wr_addr | output | 16 | Register byte address |
| reg_wr_data | output | 32 | Register write data |
| exec_pulse | output | 1 | Drawing start pulse |
| eng_busy | input | 1 | Drawing engine busy |
| stream_mode | output | 2 | Stream mode from the start pointer |
| alt_path | output | 1 | Alternate transfer path selected |
| status_word | output | 32 | Status word |
| idle | output | 1 | Decoder and engine idle |

## Verification
Packets are applied with the following headers:
- All four lanes pointing at distinct low offsets in alternating banks. This separates lane order from bank choice.
- Indices at the top and bottom of both banks. These expose errors in the offset shift and the base select.
- Headers mixing padding slots with real ones. These show whether the write count and the surviving addresses stay aligned.
- An execute slot in the last lane. This distinguishes the redirected address from the raw alias.

Directed runs stall the register bus mid-packet, hold the engine busy after an execute, and run the position exactly up to the end pointer and also into the hold bit. They also restart the decoder in mid-packet, to show that the next word is taken as a header.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

    localparam int REG_AW    = 16;
    localparam int STAT_W    = 32;
    localparam int ST_PKT    = 0;
    localparam int ST_BUSY   = 16;
    localparam int ST_END    = 17;

    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_HEAD = 2'd1,
        ST_BODY = 2'd2,
        ST_SYNC = 2'd3
    } dec_state_e;

    typedef struct packed {
        logic [REG_AW-1:0] addr;
        logic              is_pad;
        logic              is_exec;
    } slot_dec_t;

endpackage

// File: rtl/cmdq_ptr.sv
module cmdq_ptr #(
    parameter int PTR_W = 32,
    parameter int STEP  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_wr,
    input  logic [PTR_W-1:0] start_val,
    input  logic             end_wr,
    input  logic [PTR_W-1:0] end_val,
    input  logic             word_take,
    output logic             run,
    output logic [1:0]       stream_mode,
    output logic             alt_path
);

    logic [PTR_W-1:0] pos_q;
    logic [PTR_W-1:0] end_q;
    logic [1:0]       mode_q;
    logic [PTR_W-1:0] end_lim;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q  <= '0;
            mode_q <= '0;
        end else if (start_wr) begin
            pos_q  <= {start_val[PTR_W-1:2], 2'b00};
            mode_q <= start_val[1:0];
        end else if (word_take) begin
            pos_q  <= pos_q + PTR_W'(STEP);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            end_q <= '0;
        end else if (end_wr) begin
            end_q <= end_val;
        end
    end

    assign end_lim     = {end_q[PTR_W-1:2], 2'b00};
    assign run         = !end_q[0] && (pos_q < end_lim);
    assign stream_mode = mode_q;
    assign alt_path    = end_q[1];

endmodule

// File: rtl/cmdq_slot_map.sv
module cmdq_slot_map
    import cmdq_pkg::*;
#(
    parameter int              IDX_W    = 8,
    parameter logic [REG_AW-1:0] BANK0  = 16'h1C00,
    parameter logic [REG_AW-1:0] BANK1  = 16'h2C00,
    parameter logic [REG_AW-1:0] CTRL   = 16'h1C00,
    parameter logic [REG_AW-1:0] EXEC_OFS = 16'h0100,
    parameter logic [REG_AW-1:0] PAD    = 16'h1C54
) (
    input  logic [IDX_W-1:0] idx,
    output slot_dec_t        dec
);

    localparam logic [REG_AW-1:0] EXEC_ADDR = CTRL + EXEC_OFS;

    logic [REG_AW-1:0] base;
    logic [REG_AW-1:0] raw;

    always_comb begin
        base        = idx[IDX_W-1] ? BANK1 : BANK0;
        raw         = base + REG_AW'({idx[IDX_W-2:0], 2'b00});
        dec.is_exec = (raw == EXEC_ADDR);
        dec.is_pad  = (raw == PAD);
        dec.addr    = dec.is_exec ? CTRL : raw;
    end

endmodule

// File: rtl/cmdq_fsm.sv
module cmdq_fsm
    import cmdq_pkg::*;
#(
    parameter int SLOTS  = 4,
    parameter int LANE_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              run,
    input  logic              word_valid,
    input  logic              slot_free,
    input  logic              lane_exec,
    input  logic              out_pending,
    input  logic              eng_busy,
    output dec_state_e        state,
    output logic [LANE_W-1:0] lane,
    output logic              word_ready,
    output logic              take_hdr,
    output logic              take_data,
    output logic              in_pkt
);

    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(SLOTS - 1);

    dec_state_e nxt;
    logic       exec_seen;
    logic       take;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HALT;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_HALT: if (run) nxt = ST_HEAD;
            ST_HEAD: begin
                if (!run)      nxt = ST_HALT;
                else if (take) nxt = ST_BODY;
            end
            ST_BODY: begin
                if (take && lane == LAST_LANE)
                    nxt = (exec_seen || lane_exec) ? ST_SYNC : ST_HEAD;
            end
            ST_SYNC: if (!out_pending && !eng_busy) nxt = ST_HEAD;
            default: nxt = ST_HALT;
        endcase
        if (soft_rst) nxt = ST_HEAD;
    end

    always_comb begin
        word_ready = 1'b0;
        in_pkt     = out_pending;
        unique case (state)
            ST_HALT: word_ready = 1'b0;
            ST_HEAD: word_ready = run;
            ST_BODY: begin
                word_ready = run && slot_free;
                in_pkt     = 1'b1;
            end
            ST_SYNC: in_pkt = 1'b1;
            default: word_ready = 1'b0;
        endcase
        take      = word_valid && word_ready;
        take_hdr  = take && (state == ST_HEAD);
        take_data = take && (state == ST_BODY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane      <= '0;
            exec_seen <= 1'b0;
        end else if (soft_rst || take_hdr) begin
            lane      <= '0;
            exec_seen <= 1'b0;
        end else if (take_data) begin
            lane      <= (lane == LAST_LANE) ? '0 : lane + LANE_W'(1);
            exec_seen <= exec_seen || lane_exec;
        end
    end

endmodule

// File: rtl/cmdq_decoder.sv
module cmdq_decoder
    import cmdq_pkg::*;
#(
    parameter int                DATA_W   = 32,
    parameter int                PTR_W    = 32,
    parameter int                SLOTS    = 4,
    parameter logic [REG_AW-1:0] BANK0    = 16'h1C00,
    parameter logic [REG_AW-1:0] BANK1    = 16'h2C00,
    parameter logic [REG_AW-1:0] CTRL     = 16'h1C00,
    parameter logic [REG_AW-1:0] EXEC_OFS = 16'h0100,
    parameter logic [REG_AW-1:0] PAD      = 16'h1C54
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              start_wr,
    input  logic [PTR_W-1:0]  start_val,
    input  logic              end_wr,
    input  logic [PTR_W-1:0]  end_val,
    input  logic              word_valid,
    input  logic [DATA_W-1:0] word_data,
    output logic              word_ready,
    output logic              reg_wr_valid,
    input  logic              reg_wr_ready,
    output logic [REG_AW-1:0] reg_wr_addr,
    output logic [DATA_W-1:0] reg_wr_data,
    output logic              exec_pulse,
    input  logic              eng_busy,
    output logic [1:0]        stream_mode,
    output logic              alt_path,
    output logic [STAT_W-1:0] status_word,
    output logic              idle
);

    localparam int IDX_W  = DATA_W / SLOTS;
    localparam int LANE_W = $clog2(SLOTS);

    dec_state_e        state;
    logic [LANE_W-1:0] lane;
    logic              run;
    logic              take_hdr;
    logic              take_data;
    logic              in_pkt;
    logic              slot_free;
    logic [DATA_W-1:0] hdr_q;
    slot_dec_t         lane_dec [SLOTS];
    slot_dec_t         cur;
    logic              wr_valid_q;
    logic              wr_exec_q;
    logic [REG_AW-1:0] wr_addr_q;
    logic [DATA_W-1:0] wr_data_q;

    cmdq_ptr #(.PTR_W(PTR_W), .STEP(DATA_W / 8)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_wr   (start_wr),
        .start_val  (start_val),
        .end_wr     (end_wr),
        .end_val    (end_val),
        .word_take  (word_valid && word_ready),
        .run        (run),
        .stream_mode(stream_mode),
        .alt_path   (alt_path)
    );

    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_lane
            cmdq_slot_map #(
                .IDX_W   (IDX_W),
                .BANK0   (BANK0),
                .BANK1   (BANK1),
                .CTRL    (CTRL),
                .EXEC_OFS(EXEC_OFS),
                .PAD     (PAD)
            ) u_map (
                .idx(hdr_q[g*IDX_W +: IDX_W]),
                .dec(lane_dec[g])
            );
        end
    endgenerate

    assign cur       = lane_dec[lane];
    assign slot_free = !wr_valid_q || reg_wr_ready;

    cmdq_fsm #(.SLOTS(SLOTS), .LANE_W(LANE_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .run        (run),
        .word_valid (word_valid),
        .slot_free  (slot_free),
        .lane_exec  (cur.is_exec),
        .out_pending(wr_valid_q),
        .eng_busy   (eng_busy),
        .state      (state),
        .lane       (lane),
        .word_ready (word_ready),
        .take_hdr   (take_hdr),
        .take_data  (take_data),
        .in_pkt     (in_pkt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hdr_q <= '0;
        else if (take_hdr) hdr_q <= word_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_valid_q <= 1'b0;
            wr_exec_q  <= 1'b0;
            wr_addr_q  <= '0;
            wr_data_q  <= '0;
        end else if (soft_rst) begin
            wr_valid_q <= 1'b0;
            wr_exec_q  <= 1'b0;
        end else if (take_data) begin
            wr_valid_q <= !cur.is_pad;
            wr_exec_q  <= cur.is_exec;
            wr_addr_q  <= cur.addr;
            wr_data_q  <= word_data;
        end else if (reg_wr_ready) begin
            wr_valid_q <= 1'b0;
            wr_exec_q  <= 1'b0;
        end
    end

    assign reg_wr_valid = wr_valid_q;
    assign reg_wr_addr  = wr_addr_q;
    assign reg_wr_data  = wr_data_q;
    assign exec_pulse   = wr_valid_q && reg_wr_ready && wr_exec_q;

    always_comb begin
        status_word          = '0;
        status_word[ST_PKT]  = in_pkt;
        status_word[ST_BUSY] = eng_busy;
        status_word[ST_END]  = !run;
        idle = status_word[ST_END] && !status_word[ST_BUSY] && !status_word[ST_PKT];
    end

endmodule

// File: rtl/cmdq_decoder_chk.sv
module cmdq_decoder_chk
    import cmdq_pkg::*;
#(
    parameter int                DATA_W = 32,
    parameter logic [REG_AW-1:0] BANK0  = 16'h1C00,
    parameter logic [REG_AW-1:0] BANK1  = 16'h2C00,
    parameter logic [REG_AW-1:0] CTRL   = 16'h1C00,
    parameter logic [REG_AW-1:0] PAD    = 16'h1C54
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst,
    input logic              word_ready,
    input logic              reg_wr_valid,
    input logic              reg_wr_ready,
    input logic [REG_AW-1:0] reg_wr_addr,
    input logic [DATA_W-1:0] reg_wr_data,
    input logic              exec_pulse,
    input logic [STAT_W-1:0] status_word
);

    localparam logic [REG_AW-1:0] SPAN = 16'h01FF;

    a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_valid && !reg_wr_ready && !soft_rst) |=>
            (reg_wr_valid && $stable(reg_wr_addr) && $stable(reg_wr_data)));

    a_r3_exec_on_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        exec_pulse |-> (reg_wr_valid && reg_wr_ready && reg_wr_addr == CTRL));

    a_r4_no_pad_write: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_valid |-> (reg_wr_addr != PAD));

    a_r2_bank_range: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_valid |-> ((reg_wr_addr >= BANK0 && reg_wr_addr <= BANK0 + SPAN) ||
                          (reg_wr_addr >= BANK1 && reg_wr_addr <= BANK1 + SPAN)));

    a_r6_stop_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        word_ready |-> !status_word[ST_END]);

    a_r10_soft_drop: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !reg_wr_valid);

endmodule

bind cmdq_decoder cmdq_decoder_chk #(
    .DATA_W(DATA_W),
    .BANK0 (BANK0),
    .BANK1 (BANK1),
    .CTRL  (CTRL),
    .PAD   (PAD)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .word_ready  (word_ready),
    .reg_wr_valid(reg_wr_valid),
    .reg_wr_ready(reg_wr_ready),
    .reg_wr_addr (reg_wr_addr),
    .reg_wr_data (reg_wr_data),
    .exec_pulse  (exec_pulse),
    .status_word (status_word)
);

// File: tb/sim_cmdq_decoder.sv
module sim_cmdq_decoder;

    localparam int CLK_P = 10;
    localparam int NVEC  = 5;

    localparam logic [31:0] VEC [NVEC][5] = '{
        '{32'h8302_8101, 32'hA000_0001, 32'hA000_0002, 32'hA000_0003, 32'hA000_0004},
        '{32'hFF7F_8000, 32'hB111_1111, 32'hB222_2222, 32'hB333_3333, 32'hB444_4444},
        '{32'h1515_0515, 32'hC000_0010, 32'hC000_0020, 32'hC000_0030, 32'hC000_0040},
        '{32'h4033_B310, 32'hD000_0100, 32'hD000_0200, 32'hD000_0300, 32'hD000_0400},
        '{32'h1234_5678, 32'hE000_1000, 32'hE000_2000, 32'hE000_3000, 32'hE000_4000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        start_wr = 1'b0;
    logic [31:0] start_val = '0;
    logic        end_wr = 1'b0;
    logic [31:0] end_val = '0;
    logic        word_valid = 1'b0;
    logic [31:0] word_data = '0;
    logic        word_ready;
    logic        reg_wr_valid;
    logic        reg_wr_ready = 1'b1;
    logic [15:0] reg_wr_addr;
    logic [31:0] reg_wr_data;
    logic        exec_pulse;
    logic        eng_busy = 1'b0;
    logic [1:0]  stream_mode;
    logic        alt_path;
    logic [31:0] status_word;
    logic        idle;

    int nchk = 0;
    int nfail = 0;
    int ncap = 0;
    int nexec = 0;
    logic [15:0] cap_addr [16];
    logic [31:0] cap_data [16];

    always #(CLK_P/2) clk = ~clk;

    cmdq_decoder u0 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .start_wr(start_wr), .start_val(start_val),
        .end_wr(end_wr), .end_val(end_val),
        .word_valid(word_valid), .word_data(word_data), .word_ready(word_ready),
        .reg_wr_valid(reg_wr_valid), .reg_wr_ready(reg_wr_ready),
        .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .exec_pulse(exec_pulse), .eng_busy(eng_busy),
        .stream_mode(stream_mode), .alt_path(alt_path),
        .status_word(status_word), .idle(idle)
    );

    always @(negedge clk) begin
        if (reg_wr_valid && reg_wr_ready && ncap < 16) begin
            cap_addr[ncap] = reg_wr_addr;
            cap_data[ncap] = reg_wr_data;
            ncap = ncap + 1;
        end
        if (exec_pulse) nexec = nexec + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] map_idx(input logic [7:0] ix);
        logic [15:0] a;
        a = (ix[7] ? 16'h2C00 : 16'h1C00) + {7'd0, ix[6:0], 2'b00};
        if (a == 16'h1D00) a = 16'h1C00;
        return a;
    endfunction

    task automatic send_word(input logic [31:0] w);
        @(posedge clk); #1;
        word_valid = 1'b1;
        word_data  = w;
        do @(negedge clk); while (!word_ready);
        @(posedge clk); #1;
        word_valid = 1'b0;
    endtask

    task automatic set_ptrs(input logic [31:0] s, input logic [31:0] e);
        @(posedge clk); #1;
        start_wr = 1'b1; start_val = s;
        end_wr   = 1'b1; end_val   = e;
        @(posedge clk); #1;
        start_wr = 1'b0; end_wr = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_P * 100000);
        nfail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int exp_n;
        logic [15:0] ea [4];
        logic [31:0] ed [4];
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 ready", {31'd0, word_ready}, 32'd0);
        chk("R11 wr_valid", {31'd0, reg_wr_valid}, 32'd0);
        chk("R11 status end bit", {31'd0, status_word[17]}, 32'd1);
        chk("R11 idle", {31'd0, idle}, 32'd1);

        // R5 mode from start; R6 alt path from end bit 1
        set_ptrs(32'h0000_1002, 32'h0000_2002);
        @(negedge clk);
        chk("R5 stream_mode", {30'd0, stream_mode}, 32'd2);
        chk("R6 alt_path", {31'd0, alt_path}, 32'd1);
        chk("R7 running clears end bit", {31'd0, status_word[17]}, 32'd0);

        // R1 R2 R3 R4: table of packets
        for (int v = 0; v < NVEC; v++) begin
            ncap = 0; nexec = 0; exp_n = 0;
            for (int k = 0; k < 4; k++) begin
                logic [15:0] a;
                a = (VEC[v][0][8*k +: 8][7] ? 16'h2C00 : 16'h1C00) + {7'd0, VEC[v][0][8*k +: 7], 2'b00};
                if (a != 16'h1C54) begin
                    ea[exp_n] = map_idx(VEC[v][0][8*k +: 8]);
                    ed[exp_n] = VEC[v][k+1];
                    exp_n++;
                end
            end
            for (int w = 0; w < 5; w++) send_word(VEC[v][w]);
            idle_cycles(4);
            chk("R4 write count", ncap, exp_n);
            for (int j = 0; j < exp_n && j < ncap; j++) begin
                chk("R2 lane address", {16'd0, cap_addr[j]}, {16'd0, ea[j]});
                chk("R1 lane data order", cap_data[j], ed[j]);
            end
            chk("R3 exec pulses", nexec, (v == 3) ? 1 : 0);
        end
        // R2 explicit bank edges, R3 explicit redirect
        ncap = 0;
        for (int w = 0; w < 5; w++) send_word(VEC[1][w]);
        idle_cycles(4);
        chk("R2 bank1 top", {16'd0, cap_addr[3]}, 32'h2DFC);
        chk("R2 bank0 top", {16'd0, cap_addr[2]}, 32'h1DFC);
        ncap = 0;
        for (int w = 0; w < 5; w++) send_word(VEC[3][w]);
        idle_cycles(4);
        chk("R3 exec redirected to control", {16'd0, cap_addr[3]}, 32'h1C00);

        // R8 stall
        ncap = 0;
        send_word(32'h0302_0100);
        @(posedge clk); #1 reg_wr_ready = 1'b0;
        send_word(32'h5555_0001);
        @(posedge clk); #1;
        word_valid = 1'b1; word_data = 32'h5555_0002;
        @(negedge clk); @(negedge clk);
        chk("R8 ready low while stalled", {31'd0, word_ready}, 32'd0);
        chk("R8 write held", {31'd0, reg_wr_valid}, 32'd1);
        chk("R8 address held", {16'd0, reg_wr_addr}, 32'h1C00);
        chk("R7 packet bit mid packet", {31'd0, status_word[0]}, 32'd1);
        @(posedge clk); #1 reg_wr_ready = 1'b1;
        do @(negedge clk); while (!word_ready);
        @(posedge clk); #1 word_valid = 1'b0;
        send_word(32'h5555_0003);
        send_word(32'h5555_0004);
        idle_cycles(4);
        chk("R8 all writes after stall", ncap, 4);
        chk("R8 second write data", cap_data[1], 32'h5555_0002);

        // R9 engine sync after execute
        eng_busy = 1'b1;
        for (int w = 0; w < 5; w++) send_word(VEC[3][w]);
        @(posedge clk); #1;
        word_valid = 1'b1; word_data = 32'h0000_0001;
        idle_cycles(5);
        @(negedge clk);
        chk("R9 header held off while busy", {31'd0, word_ready}, 32'd0);
        chk("R7 busy bit", {31'd0, status_word[16]}, 32'd1);
        chk("R7 not idle while busy", {31'd0, idle}, 32'd0);
        @(posedge clk); #1 eng_busy = 1'b0;
        do @(negedge clk); while (!word_ready);
        @(posedge clk); #1 word_valid = 1'b0;
        ncap = 0;
        for (int w = 1; w < 5; w++) send_word(32'h7700_0000 + w);
        idle_cycles(4);
        chk("R9 packet after release", {16'd0, cap_addr[0]}, 32'h1C04);

        // R10 soft reset mid packet
        send_word(32'h0101_0101);
        send_word(32'h1111_0001);
        send_word(32'h1111_0002);
        @(posedge clk); #1 soft_rst = 1'b1;
        @(posedge clk); #1 soft_rst = 1'b0;
        idle_cycles(2);
        ncap = 0;
        @(negedge clk);
        chk("R10 packet bit cleared", {31'd0, status_word[0]}, 32'd0);
        send_word(32'h0504_0302);
        for (int w = 1; w < 5; w++) send_word(32'h2222_0000 + w);
        idle_cycles(4);
        chk("R10 new header decoded", ncap, 4);
        chk("R10 first address", {16'd0, cap_addr[0]}, 32'h1C08);
        chk("R10 last address", {16'd0, cap_addr[3]}, 32'h1C14);

        // R5 R6 stop exactly at end: start 0x3001, end 0x3000+40 (two packets)
        set_ptrs(32'h0000_3001, 32'h0000_3028);
        @(negedge clk);
        chk("R5 mode reload", {30'd0, stream_mode}, 32'd1);
        for (int p = 0; p < 2; p++)
            for (int w = 0; w < 5; w++) send_word(VEC[0][w]);
        idle_cycles(3);
        @(negedge clk);
        chk("R6 stopped at end", {31'd0, word_ready}, 32'd0);
        chk("R7 end bit at end", {31'd0, status_word[17]}, 32'd1);
        chk("R7 idle at end", {31'd0, idle}, 32'd1);

        // R6 hold bit in end value
        set_ptrs(32'h0000_4000, 32'h0000_5001);
        idle_cycles(2);
        @(negedge clk);
        chk("R6 hold bit blocks", {31'd0, word_ready}, 32'd0);
        chk("R6 alt path off", {31'd0, alt_path}, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule